// File: doc/BRIEF.md
# Calibration Pattern Readout Controller

This block sits on the command side of a DDR3-class memory device and handles its calibration readout mode. It watches a stream of decoded commands, one per clock. A mode-register write aimed at register 3 with address bit 2 set turns the mode on. The same write with that bit clear turns it off again. While the mode is on, every read returns a fixed training burst instead of going to the memory array, and any other command is rejected. The controller therefore keeps its own view of which banks are open and whether the precharge recovery time has run out, so it can refuse to enter the mode while the array is busy.

In normal operation, accepted array commands leave through a one-cycle forward strobe toward the core. While the mode is on, reads are served locally. The burst starts a fixed number of cycles after the command, and one beat is delivered per clock with a valid strobe. Address bits 1:0 of the enabling write choose the pattern location. A rejected command raises a one-cycle error pulse and leaves every piece of internal state as it was.

Top module: `cal_readout_ctrl`

## Requirements
- R1: After the synchronous reset, err, core_fwd, rd_valid and rd_data are all 0, the mode is off, all banks count as closed, and no recovery time is pending. An enabling write issued straight after reset is therefore accepted.
- R2: Command codes on cmd_op are 0 NOP, 1 MRS, 2 ACT, 3 RD, 4 RDA, 5 WR, 6 PRE, 7 REF, 8 SRE and 9 PDE. Codes 10 to 15 are treated as NOP. With the mode off, codes 2 to 9 are accepted and core_fwd is 1 in the cycle after the edge that samples them. No read data is produced.
- R3: An MRS with cmd_bank equal to 3 and cmd_addr[2]=1 enables the mode only when every bank is closed and at least TRP cycles have passed since the last closing command. Closing commands are PRE, or RDA while the mode is off. With TRP=3, an enable sampled 2 cycles after a PRE is rejected and one sampled 3 cycles after is accepted. An enable issued while a bank is open is rejected.
- R4: With the mode on, RD and RDA give no core_fwd and no err. They start a burst in which rd_valid is 1 for BL consecutive cycles. The first valid cycle comes CL cycles after the cycle that follows the sampling edge. Reads spaced BL cycles apart give back-to-back bursts.
- R5: The pattern location is cmd_addr[1:0] of the accepted enabling write. Location 0 returns all lanes 0 on even beats and all lanes 1 on odd beats, starting with beat 0. Locations 1 to 3 return all zeros. Rejected writes do not change the location.
- R6: While the mode is on, RDA acts exactly as RD: it starts no recovery time and changes no bank state.
- R7: While the mode is on, ACT, WR, PRE, REF, SRE, PDE, an MRS to any register other than 3, and an MRS to register 3 with bit 2 set each give err=1 for one cycle after the sampling edge and no core_fwd. They leave the mode, the location, the bank flags and the recovery time unchanged.
- R8: While the mode is on, an MRS with cmd_bank equal to 3 and cmd_addr[2]=0 turns the mode off without an error. Later reads are forwarded again.
- R9: The reset input is honoured while the mode is on and returns the mode to off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_op | input | 4 | Decoded command code |
| cmd_bank | input | BANK_W | Bank index; selects the mode register on MRS |
| cmd_addr | input | 3 | Low address bits: [2] mode enable, [1:0] pattern location |
| core_fwd | output | 1 | Accepted command forwarded to the array path |
| rd_valid | output | 1 | Pattern beat valid |
| rd_data | output | DQ_W | Pattern beat data |
| err | output | 1 | One-cycle pulse per rejected command |

## Verification
The bench builds the block with CL=3, TRP=3, BL=8 and DQ_W=8 instead of the larger defaults. The short recovery time puts the last rejected and first accepted enabling writes only a few commands after a precharge, so the boundary on both sides is hit exactly. It also makes a precharge that was wrongly accepted in the mode, or an auto-precharge that was wrongly honoured, visible as a rejected re-entry two commands later. The short latency keeps overlapping, back-to-back and in-flight bursts close to the commands that alter the mode around them.

// File: rtl/cal_readout_pkg.sv
package cal_readout_pkg;

  typedef enum logic [3:0] {
    OP_NOP = 4'd0,
    OP_MRS = 4'd1,
    OP_ACT = 4'd2,
    OP_RD  = 4'd3,
    OP_RDA = 4'd4,
    OP_WR  = 4'd5,
    OP_PRE = 4'd6,
    OP_REF = 4'd7,
    OP_SRE = 4'd8,
    OP_PDE = 4'd9
  } cal_op_e;

  localparam int CAL_MR_INDEX = 3;

endpackage

// File: rtl/cal_cmd_decode.sv
module cal_cmd_decode
  import cal_readout_pkg::*;
#(
  parameter int BANK_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        op_raw,
  input  logic [BANK_W-1:0] bank,
  input  logic [2:0]        addr,
  input  logic              banks_idle,
  output logic              mode_on,
  output logic [1:0]        loc_q,
  output logic              pat_rd,
  output logic              fwd,
  output logic              reject,
  output logic              trk_open,
  output logic              trk_close
);

  cal_op_e    op;
  logic       is_mr3;
  logic       mode_d;
  logic [1:0] loc_d;

  assign op     = cal_op_e'(op_raw);
  assign is_mr3 = (bank == BANK_W'(CAL_MR_INDEX));

  always_comb begin
    mode_d    = mode_on;
    loc_d     = loc_q;
    pat_rd    = 1'b0;
    fwd       = 1'b0;
    reject    = 1'b0;
    trk_open  = 1'b0;
    trk_close = 1'b0;
    case (op)
      OP_MRS: begin
        if (mode_on) begin
          if (is_mr3 && !addr[2]) mode_d = 1'b0;
          else                    reject = 1'b1;
        end else if (is_mr3 && addr[2]) begin
          if (banks_idle) begin
            mode_d = 1'b1;
            loc_d  = addr[1:0];
          end else begin
            reject = 1'b1;
          end
        end
      end
      OP_RD, OP_RDA: begin
        if (mode_on) begin
          pat_rd = 1'b1;
        end else begin
          fwd       = 1'b1;
          trk_close = (op == OP_RDA);
        end
      end
      OP_ACT: begin
        if (mode_on) reject = 1'b1;
        else begin
          fwd      = 1'b1;
          trk_open = 1'b1;
        end
      end
      OP_PRE: begin
        if (mode_on) reject = 1'b1;
        else begin
          fwd       = 1'b1;
          trk_close = 1'b1;
        end
      end
      OP_WR, OP_REF, OP_SRE, OP_PDE: begin
        if (mode_on) reject = 1'b1;
        else         fwd    = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_on <= 1'b0;
      loc_q   <= 2'd0;
    end else begin
      mode_on <= mode_d;
      loc_q   <= loc_d;
    end
  end

endmodule

// File: rtl/cal_bank_track.sv
module cal_bank_track #(
  parameter int BANK_W = 3,
  parameter int TRP    = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BANK_W-1:0] bank,
  input  logic              open_req,
  input  logic              close_req,
  output logic              banks_idle
);

  localparam int NB = 1 << BANK_W;
  localparam int CW = (TRP < 2) ? 1 : $clog2(TRP);

  logic [NB-1:0] open_q;
  logic [CW-1:0] rec_cnt;

  for (genvar i = 0; i < NB; i++) begin : g_bank
    logic hit;
    assign hit = (bank == BANK_W'(i));
    always_ff @(posedge clk) begin
      if (rst)                   open_q[i] <= 1'b0;
      else if (hit && open_req)  open_q[i] <= 1'b1;
      else if (hit && close_req) open_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 rec_cnt <= '0;
    else if (close_req)      rec_cnt <= CW'(TRP - 1);
    else if (rec_cnt != '0)  rec_cnt <= rec_cnt - 1'b1;
  end

  assign banks_idle = (open_q == '0) && (rec_cnt == '0);

endmodule

// File: rtl/cal_pattern_burst.sv
module cal_pattern_burst #(
  parameter int DQ_W = 16,
  parameter int CL   = 5,
  parameter int BL   = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [1:0]      loc,
  output logic            rd_valid,
  output logic [DQ_W-1:0] rd_data
);

  localparam int BW = $clog2(BL);

  logic [CL-1:0] dv;
  logic [1:0]    dl [CL];
  logic          active;
  logic [BW-1:0] beat;
  logic [1:0]    hold_loc;

  function automatic logic [DQ_W-1:0] beat_word(input logic [1:0] l, input logic [BW-1:0] b);
    return (l == 2'd0) ? {DQ_W{b[0]}} : '0;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) dv[0] <= 1'b0;
    else     dv[0] <= start;
    dl[0] <= loc;
  end

  for (genvar i = 1; i < CL; i++) begin : g_lat
    always_ff @(posedge clk) begin
      if (rst) dv[i] <= 1'b0;
      else     dv[i] <= dv[i-1];
      dl[i] <= dl[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      beat     <= '0;
      hold_loc <= 2'd0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (dv[CL-1]) begin
      active   <= 1'b1;
      beat     <= BW'(1);
      hold_loc <= dl[CL-1];
      rd_valid <= 1'b1;
      rd_data  <= beat_word(dl[CL-1], '0);
    end else if (active) begin
      rd_valid <= 1'b1;
      rd_data  <= beat_word(hold_loc, beat);
      beat     <= beat + 1'b1;
      if (beat == BW'(BL - 1)) active <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end
  end

endmodule

// File: rtl/cal_readout_ctrl.sv
module cal_readout_ctrl #(
  parameter int BANK_W = 3,
  parameter int DQ_W   = 16,
  parameter int CL     = 5,
  parameter int TRP    = 6,
  parameter int BL     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        cmd_op,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [2:0]        cmd_addr,
  output logic              core_fwd,
  output logic              rd_valid,
  output logic [DQ_W-1:0]   rd_data,
  output logic              err
);

  logic       mode_on;
  logic [1:0] loc_q;
  logic       pat_rd;
  logic       fwd;
  logic       reject;
  logic       trk_open;
  logic       trk_close;
  logic       banks_idle;

  cal_cmd_decode #(.BANK_W(BANK_W)) u_dec (
    .clk        (clk),
    .rst        (rst),
    .op_raw     (cmd_op),
    .bank       (cmd_bank),
    .addr       (cmd_addr),
    .banks_idle (banks_idle),
    .mode_on    (mode_on),
    .loc_q      (loc_q),
    .pat_rd     (pat_rd),
    .fwd        (fwd),
    .reject     (reject),
    .trk_open   (trk_open),
    .trk_close  (trk_close)
  );

  cal_bank_track #(.BANK_W(BANK_W), .TRP(TRP)) u_trk (
    .clk        (clk),
    .rst        (rst),
    .bank       (cmd_bank),
    .open_req   (trk_open),
    .close_req  (trk_close),
    .banks_idle (banks_idle)
  );

  cal_pattern_burst #(.DQ_W(DQ_W), .CL(CL), .BL(BL)) u_burst (
    .clk      (clk),
    .rst      (rst),
    .start    (pat_rd),
    .loc      (loc_q),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      err      <= 1'b0;
      core_fwd <= 1'b0;
    end else begin
      err      <= reject;
      core_fwd <= fwd;
    end
  end

endmodule

// File: rtl/cal_readout_chk.sv
module cal_readout_chk
  import cal_readout_pkg::*;
#(
  parameter int BANK_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        cmd_op,
  input logic [BANK_W-1:0] cmd_bank,
  input logic [2:0]        cmd_addr,
  input logic              mode_on,
  input logic              banks_idle,
  input logic              err,
  input logic              core_fwd,
  input logic              rd_valid
);

  logic is_mr3;
  logic is_illegal;
  logic is_read;

  assign is_mr3     = (cmd_op == 4'(OP_MRS)) && (cmd_bank == BANK_W'(3));
  assign is_read    = (cmd_op == 4'(OP_RD)) || (cmd_op == 4'(OP_RDA));
  assign is_illegal = (cmd_op == 4'(OP_ACT)) || (cmd_op == 4'(OP_WR)) ||
                      (cmd_op == 4'(OP_PRE)) || (cmd_op == 4'(OP_REF)) ||
                      (cmd_op == 4'(OP_SRE)) || (cmd_op == 4'(OP_PDE));

  AST_ERR_FWD_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(err && core_fwd)); // R7

  AST_READ_REDIRECT: assert property (@(posedge clk) disable iff (rst)
    (mode_on && is_read) |=> (!core_fwd && !err)); // R4

  AST_ILLEGAL_FLAG: assert property (@(posedge clk) disable iff (rst)
    (mode_on && is_illegal) |=> (err && mode_on && !core_fwd)); // R7

  AST_ENABLE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (!mode_on && is_mr3 && cmd_addr[2] && !banks_idle) |=> (err && !mode_on)); // R3

  AST_EXIT_CLEAN: assert property (@(posedge clk) disable iff (rst)
    (mode_on && is_mr3 && !cmd_addr[2]) |=> (!mode_on && !err)); // R8

  AST_RESET_OFF: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!mode_on && !rd_valid && !err)); // R9

endmodule

bind cal_readout_ctrl cal_readout_chk #(.BANK_W(BANK_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_op     (cmd_op),
  .cmd_bank   (cmd_bank),
  .cmd_addr   (cmd_addr),
  .mode_on    (mode_on),
  .banks_idle (banks_idle),
  .err        (err),
  .core_fwd   (core_fwd),
  .rd_valid   (rd_valid)
);

// File: tb/cal_readout_ctrl_bench.sv
module cal_readout_ctrl_bench;
  import cal_readout_pkg::*;

  localparam int CLK_P  = 10;
  localparam int BANK_W = 3;
  localparam int DQ_W   = 8;
  localparam int CL     = 3;
  localparam int TRP    = 3;
  localparam int BL     = 8;

  logic              clk;
  logic              rst;
  logic [3:0]        op_i;
  logic [BANK_W-1:0] bank_i;
  logic [2:0]        addr_i;
  logic              core_fwd;
  logic              rd_valid;
  logic [DQ_W-1:0]   rd_data;
  logic              err;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  int              exp_c [$];
  logic [DQ_W-1:0] exp_d [$];

  cal_readout_ctrl #(
    .BANK_W(BANK_W), .DQ_W(DQ_W), .CL(CL), .TRP(TRP), .BL(BL)
  ) u_cal_readout_ctrl (
    .clk      (clk),
    .rst      (rst),
    .cmd_op   (op_i),
    .cmd_bank (bank_i),
    .cmd_addr (addr_i),
    .core_fwd (core_fwd),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .err      (err)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input string what,
                     input logic [DQ_W-1:0] act, input logic [DQ_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Driver: called at a negedge, returns at the next negedge after checking the response.
  task automatic cmd(input cal_op_e op, input int bank, input logic [2:0] a,
                     input logic e_err, input logic e_fwd, input int pat_loc,
                     input string req);
    op_i   = op;
    bank_i = BANK_W'(bank);
    addr_i = a;
    if (pat_loc >= 0) begin
      for (int b = 0; b < BL; b++) begin
        exp_c.push_back(cyc + 1 + CL + b);
        exp_d.push_back((pat_loc == 0) ? {DQ_W{b[0]}} : '0);
      end
    end
    @(negedge clk);
    chk(req, "err", DQ_W'(err), DQ_W'(e_err));
    chk(req, "core_fwd", DQ_W'(core_fwd), DQ_W'(e_fwd));
    op_i = OP_NOP;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops expected beats and compares them with the produced ones.
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (rd_valid) begin
        checks++;
        if (exp_c.size() == 0) begin
          fails++;
          $display("FAIL R4 unexpected beat: actual %h expected none", rd_data);
        end else begin
          int ec;
          logic [DQ_W-1:0] ed;
          ec = exp_c.pop_front();
          ed = exp_d.pop_front();
          if (ec != cyc || ed !== rd_data) begin
            fails++;
            $display("FAIL R4/R5 beat: actual cycle %0d data %h expected cycle %0d data %h",
                     cyc, rd_data, ec, ed);
          end
        end
      end else if (exp_c.size() > 0 && exp_c[0] <= cyc) begin
        checks++;
        fails++;
        $display("FAIL R4 missing beat: actual none expected cycle %0d data %h",
                 exp_c[0], exp_d[0]);
        void'(exp_c.pop_front());
        void'(exp_d.pop_front());
      end
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; op_i = OP_NOP; bank_i = '0; addr_i = '0;
    idle(3);
    rst = 1'b0;
    chk("R1", "err", DQ_W'(err), '0);
    chk("R1", "core_fwd", DQ_W'(core_fwd), '0);
    chk("R1", "rd_valid", DQ_W'(rd_valid), '0);
    chk("R1", "rd_data", rd_data, '0);

    // R1: enable straight after reset, then a pattern read (R4, R5 location 0)
    cmd(OP_MRS, 3, 3'b100, 0, 0, -1, "R1");
    cmd(OP_RD, 0, 3'b000, 0, 0, 0, "R4");
    idle(CL + BL + 1);

    // R8: exit, reads forwarded again
    cmd(OP_MRS, 3, 3'b000, 0, 0, -1, "R8");
    cmd(OP_RD, 0, 3'b000, 0, 1, -1, "R8");

    // R2: array commands in normal mode
    cmd(OP_ACT, 2, 3'b000, 0, 1, -1, "R2");
    cmd(OP_WR, 2, 3'b000, 0, 1, -1, "R2");
    cmd(OP_REF, 0, 3'b000, 0, 1, -1, "R2");
    cmd(OP_SRE, 0, 3'b000, 0, 1, -1, "R2");
    cmd(OP_PDE, 0, 3'b000, 0, 1, -1, "R2");
    cmd(OP_MRS, 3, 3'b011, 0, 0, -1, "R2");

    // R3: bank open blocks entry
    cmd(OP_MRS, 3, 3'b100, 1, 0, -1, "R3");
    cmd(OP_RD, 2, 3'b000, 0, 1, -1, "R3");
    // R3: recovery boundary after PRE (TRP=3)
    cmd(OP_PRE, 2, 3'b000, 0, 1, -1, "R3");
    cmd(OP_NOP, 0, 3'b000, 0, 0, -1, "R3");
    cmd(OP_MRS, 3, 3'b110, 1, 0, -1, "R3");
    cmd(OP_MRS, 3, 3'b110, 0, 0, -1, "R3");
    cmd(OP_RD, 0, 3'b000, 0, 0, 2, "R5");
    idle(CL + BL + 1);

    // R7: illegal commands in mode, state unchanged
    cmd(OP_MRS, 3, 3'b100, 1, 0, -1, "R7");
    cmd(OP_RD, 0, 3'b000, 0, 0, 2, "R7");
    cmd(OP_MRS, 1, 3'b000, 1, 0, -1, "R7");
    cmd(OP_WR, 0, 3'b000, 1, 0, -1, "R7");
    cmd(OP_ACT, 4, 3'b000, 1, 0, -1, "R7");
    cmd(OP_REF, 0, 3'b000, 1, 0, -1, "R7");
    cmd(OP_SRE, 0, 3'b000, 1, 0, -1, "R7");
    cmd(OP_PDE, 0, 3'b000, 1, 0, -1, "R7");
    cmd(OP_PRE, 0, 3'b000, 1, 0, -1, "R7");
    cmd(OP_MRS, 3, 3'b000, 0, 0, -1, "R8");
    cmd(OP_MRS, 3, 3'b100, 0, 0, -1, "R7");
    idle(CL + BL + 1);

    // R6: RDA in mode starts no recovery time
    cmd(OP_RDA, 1, 3'b000, 0, 0, 0, "R6");
    cmd(OP_MRS, 3, 3'b000, 0, 0, -1, "R6");
    cmd(OP_MRS, 3, 3'b101, 0, 0, -1, "R6");
    idle(BL);
    cmd(OP_RD, 0, 3'b000, 0, 0, 1, "R5");
    idle(CL + BL + 1);

    // R4: back-to-back bursts
    cmd(OP_MRS, 3, 3'b000, 0, 0, -1, "R8");
    cmd(OP_MRS, 3, 3'b100, 0, 0, -1, "R4");
    cmd(OP_RD, 0, 3'b000, 0, 0, 0, "R4");
    for (int i = 0; i < BL - 1; i++) cmd(OP_NOP, 0, 3'b000, 0, 0, -1, "R4");
    cmd(OP_RDA, 3, 3'b000, 0, 0, 0, "R4");
    idle(CL + BL + 1);

    // R9: reset while mode is on
    rst = 1'b1;
    idle(1);
    rst = 1'b0;
    chk("R9", "rd_valid", DQ_W'(rd_valid), '0);
    cmd(OP_RD, 0, 3'b000, 0, 1, -1, "R9");

    // R3: normal-mode RDA closes its bank and starts recovery
    cmd(OP_ACT, 5, 3'b000, 0, 1, -1, "R3");
    cmd(OP_RDA, 5, 3'b000, 0, 1, -1, "R3");
    cmd(OP_MRS, 3, 3'b100, 1, 0, -1, "R3");
    cmd(OP_NOP, 0, 3'b000, 0, 0, -1, "R3");
    cmd(OP_MRS, 3, 3'b100, 0, 0, -1, "R3");
    cmd(OP_MRS, 3, 3'b000, 0, 0, -1, "R8");
    cmd(OP_RDA, 0, 3'b000, 0, 1, -1, "R8");
    idle(CL + BL + 2);

    chk("R4", "pending beats", DQ_W'(exp_c.size()), '0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule